// File: doc/BRIEF.md
# Integer Execute Stage

This block is the execute step of a 32-bit load/store-style integer core. Each cycle it takes one instruction word together with the values read for its two source registers. It decodes the word and computes one of nine integer operations. The registered outputs are the result, the destination register index, a write enable and an illegal-instruction flag. The register file sits outside the block and uses the write enable and index to decide whether to commit the result.

Two instruction layouts are recognised. The three-register layout selects add, subtract, AND, OR, NOR and three constant-distance shifts through a function code. The immediate layout is used only for add-with-constant. Add and subtract wrap modulo 2^32 and never trap. Any opcode or function code outside the supported set raises the illegal flag and suppresses the write.

Top module: `int_exec_stage`

## Requirements
- R1: Bit fields run from bit 31 down: opcode[31:26], source A index[25:21], source B index[20:16], destination index[15:11], shift distance[10:6], function[5:0]. With opcode 0 and function 32 the stage writes A+B to the destination index; word 0x02324020 adds registers 17 and 18 into register 8.
- R2: Function 34 writes A-B. Add and subtract wrap modulo 2^32 with no exception.
- R3: Function 36 writes A AND B. Function 37 writes A OR B.
- R4: Function 39 writes NOT(A OR B). With source B index 0 this is NOT A.
- R5: Function 0 shifts B left and function 2 shifts B right, both by the 5-bit shift distance (0 to 31), with zeros filling the vacated bits.
- R6: Function 3 shifts B right by the shift distance and fills the vacated high bits with B's original bit 31.
- R7: Opcode 8 writes A plus bits [15:0] sign-extended from bit 15, and the destination is the source B index field.
- R8: A source index of 0 reads as zero, whatever value is presented on the matching operand input.
- R9: A destination index of 0 keeps the write enable low, while the result is still produced.
- R10: Any opcode other than 0 or 8, and any function code outside {0,2,3,32,34,36,37,39} under opcode 0, sets the illegal flag, clears the write enable and drives the result to 0.
- R11: All outputs are registered, so they show the instruction presented before the previous rising edge. While reset (active low, synchronous) is held, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | Value of the register named by bits [25:21] |
| src_b | input | 32 | Value of the register named by bits [20:16] |
| res | output | 32 | Registered result |
| dst | output | 5 | Registered destination index |
| wr_en | output | 1 | Registered write enable |
| illegal | output | 1 | Registered illegal-instruction flag |

## Verification
The operand patterns are the 0, 1, all-ones, most-negative and most-positive words, pairwise combined:
- Wrap-around on add and subtract is what separates a modulo result from a saturating or trapping one.
- Every shift distance from 0 to 31 is applied to a word with bit 31 set. This distinguishes zero fill from sign fill and catches a stage of the shifter that is wired wrongly.
- Constants with bit 15 set and clear expose a missing sign extension.
- Garbage on an operand whose index is 0, and a destination of 0, show whether the zero register is honoured on both the read side and the write side.
- Randomised legal and illegal words are then compared with a reference model written into the bench.

// File: rtl/exu_pkg.sv
package exu_pkg;

    localparam int XLEN = 32;
    localparam int RIDX = 5;
    localparam int SHW  = $clog2(XLEN);

    localparam logic [5:0] OPC_REG  = 6'd0;
    localparam logic [5:0] OPC_ADDI = 6'd8;

    localparam logic [5:0] FN_SLL = 6'd0;
    localparam logic [5:0] FN_SRL = 6'd2;
    localparam logic [5:0] FN_SRA = 6'd3;
    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_AND = 6'd36;
    localparam logic [5:0] FN_OR  = 6'd37;
    localparam logic [5:0] FN_NOR = 6'd39;

    typedef enum logic [3:0] {
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_NOR,
        OP_SLL, OP_SRL, OP_SRA, OP_ADDI, OP_BAD
    } alu_op_e;

    typedef struct packed {
        alu_op_e         op;
        logic [RIDX-1:0] idx_a;
        logic [RIDX-1:0] idx_b;
        logic [RIDX-1:0] dst;
        logic [SHW-1:0]  shamt;
        logic [15:0]     imm;
        logic            wen;
        logic            bad;
    } dec_t;

    typedef struct packed {
        logic [XLEN-1:0] res;
        logic [RIDX-1:0] dst;
        logic            wen;
        logic            bad;
    } stage_t;

endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import exu_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);
    logic [5:0] opc;
    logic [5:0] fn;

    always_comb begin
        opc       = instr[31:26];
        fn        = instr[5:0];
        dec       = '0;
        dec.idx_a = instr[25:21];
        dec.idx_b = instr[20:16];
        dec.shamt = instr[10:6];
        dec.imm   = instr[15:0];
        dec.op    = OP_BAD;
        dec.dst   = instr[15:11];
        unique case (opc)
            OPC_REG: begin
                unique case (fn)
                    FN_ADD:  dec.op = OP_ADD;
                    FN_SUB:  dec.op = OP_SUB;
                    FN_AND:  dec.op = OP_AND;
                    FN_OR:   dec.op = OP_OR;
                    FN_NOR:  dec.op = OP_NOR;
                    FN_SLL:  dec.op = OP_SLL;
                    FN_SRL:  dec.op = OP_SRL;
                    FN_SRA:  dec.op = OP_SRA;
                    default: dec.op = OP_BAD;
                endcase
            end
            OPC_ADDI: begin
                dec.op  = OP_ADDI;
                dec.dst = instr[20:16];
            end
            default: dec.op = OP_BAD;
        endcase
        dec.bad = (dec.op == OP_BAD);
        dec.wen = !dec.bad && (dec.dst != '0);
    end
endmodule

// File: rtl/exu_adder.sv
module exu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum
);
    logic [W-1:0] b_eff;

    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = a + b_eff + {{(W-1){1'b0}}, sub};
    end
endmodule

// File: rtl/exu_shifter.sv
module exu_shifter #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    input  logic          right,
    input  logic          arith,
    output logic [W-1:0]  dout
);
    logic [W-1:0] pre;
    logic [W-1:0] stg [0:SW];
    logic         fill;

    assign fill = right & arith & din[W-1];

    for (genvar i = 0; i < W; i++) begin : g_pre
        assign pre[i] = right ? din[i] : din[W-1-i];
    end

    assign stg[0] = pre;

    for (genvar s = 0; s < SW; s++) begin : g_stage
        localparam int D = 1 << s;
        assign stg[s+1] = amt[s] ? {{D{fill}}, stg[s][W-1:D]} : stg[s];
    end

    for (genvar i = 0; i < W; i++) begin : g_post
        assign dout[i] = right ? stg[SW][i] : stg[SW][W-1-i];
    end
endmodule

// File: rtl/int_exec_stage.sv
module int_exec_stage
    import exu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] instr,
    input  logic [31:0] src_a,
    input  logic [31:0] src_b,
    output logic [31:0] res,
    output logic [4:0]  dst,
    output logic        wr_en,
    output logic        illegal
);
    dec_t            dec;
    stage_t          st_d, st_q;
    logic [XLEN-1:0] a_val, b_val, imm_ext, add_b, sum_v, shf_v;
    logic            is_sub, is_right, is_arith;

    exu_decode u_dec (.instr(instr), .dec(dec));

    assign a_val    = (dec.idx_a == '0) ? '0 : src_a;
    assign b_val    = (dec.idx_b == '0) ? '0 : src_b;
    assign imm_ext  = {{(XLEN-16){dec.imm[15]}}, dec.imm};
    assign add_b    = (dec.op == OP_ADDI) ? imm_ext : b_val;
    assign is_sub   = (dec.op == OP_SUB);
    assign is_right = (dec.op == OP_SRL) || (dec.op == OP_SRA);
    assign is_arith = (dec.op == OP_SRA);

    exu_adder #(.W(XLEN)) u_add (
        .a(a_val), .b(add_b), .sub(is_sub), .sum(sum_v)
    );

    exu_shifter #(.W(XLEN), .SW(SHW)) u_shf (
        .din(b_val), .amt(dec.shamt), .right(is_right),
        .arith(is_arith), .dout(shf_v)
    );

    always_comb begin
        st_d     = '0;
        st_d.dst = dec.dst;
        st_d.wen = dec.wen;
        st_d.bad = dec.bad;
        unique case (dec.op)
            OP_ADD, OP_SUB, OP_ADDI: st_d.res = sum_v;
            OP_AND:                  st_d.res = a_val & b_val;
            OP_OR:                   st_d.res = a_val | b_val;
            OP_NOR:                  st_d.res = ~(a_val | b_val);
            OP_SLL, OP_SRL, OP_SRA:  st_d.res = shf_v;
            default:                 st_d.res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res     = st_q.res;
    assign dst     = st_q.dst;
    assign wr_en   = st_q.wen;
    assign illegal = st_q.bad;

    // R10
    a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wr_en && res == '0));

    // R9
    a_r9_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (dst != '0));

    // R7
    a_r7_addi_dst: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(instr[31:26]) == 6'd8) |-> (dst == $past(instr[20:16])));

    // R6
    a_r6_sra_sign: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(instr[31:26]) == 6'd0) && ($past(instr[5:0]) == 6'd3)
        && ($past(instr[20:16]) != 5'd0) |-> (res[31] == $past(src_b[31])));

    // R8
    a_r8_zero_regs_or: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(instr[31:26]) == 6'd0) && ($past(instr[5:0]) == 6'd37)
        && ($past(instr[25:16]) == 10'd0) |-> (res == '0));
endmodule

// File: tb/sim_int_exec_stage.sv
module sim_int_exec_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0, src_a = '0, src_b = '0;
    logic [31:0] res;
    logic [4:0]  dst;
    logic        wr_en, illegal;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;
    logic [31:0] lfsr = 32'h1234_5678;

    always #5 clk = ~clk;

    int_exec_stage u0 (
        .clk(clk), .rst_n(rst_n), .instr(instr), .src_a(src_a), .src_b(src_b),
        .res(res), .dst(dst), .wr_en(wr_en), .illegal(illegal)
    );

    function automatic logic [31:0] rtype(input int rs, input int rt, input int rd,
                                          input int sh, input int fn);
        return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
    endfunction

    function automatic logic [31:0] itype(input int opc, input int rs, input int rt,
                                          input logic [15:0] k);
        return {opc[5:0], rs[4:0], rt[4:0], k};
    endfunction

    // Reference model built from the requirements
    task automatic model(input logic [31:0] w, input logic [31:0] av, input logic [31:0] bv,
                         output logic [31:0] e_res, output logic [4:0] e_dst,
                         output logic e_wen, output logic e_ill);
        logic [31:0] a, b;
        int          sh;
        a = (w[25:21] == 0) ? 32'd0 : av;
        b = (w[20:16] == 0) ? 32'd0 : bv;
        sh = int'(w[10:6]);
        e_ill = 1'b0; e_res = 32'd0; e_dst = w[15:11];
        if (w[31:26] == 6'd8) begin
            e_dst = w[20:16];
            e_res = a + {{16{w[15]}}, w[15:0]};
        end else if (w[31:26] == 6'd0) begin
            case (w[5:0])
                6'd32: e_res = a + b;
                6'd34: e_res = a - b;
                6'd36: e_res = a & b;
                6'd37: e_res = a | b;
                6'd39: e_res = ~(a | b);
                6'd0:  e_res = b << sh;
                6'd2:  e_res = b >> sh;
                6'd3:  e_res = 32'($signed(b) >>> sh);
                default: e_ill = 1'b1;
            endcase
        end else e_ill = 1'b1;
        e_wen = !e_ill && (e_dst != 0);
    endtask

    task automatic check(input string tag, input logic [31:0] e_res, input logic [4:0] e_dst,
                         input logic e_wen, input logic e_ill);
        n_chk++;
        if (res !== e_res || dst !== e_dst || wr_en !== e_wen || illegal !== e_ill) begin
            n_fail++;
            $display("FAIL %s: got res=%h dst=%0d wen=%b ill=%b, expected res=%h dst=%0d wen=%b ill=%b",
                     tag, res, dst, wr_en, illegal, e_res, e_dst, e_wen, e_ill);
        end
    endtask

    // drive on the falling edge, sample 1 ns after the next rising edge
    task automatic run(input string tag, input logic [31:0] w, input logic [31:0] av,
                       input logic [31:0] bv);
        logic [31:0] er; logic [4:0] ed; logic ew, ei;
        @(negedge clk);
        instr = w; src_a = av; src_b = bv;
        model(w, av, bv, er, ed, ew, ei);
        @(posedge clk); #1;
        check(tag, er, ed, ew, ei);
    endtask

    task automatic t_reset;  // R11
        @(negedge clk);
        instr = rtype(1, 2, 3, 0, 32); src_a = 5; src_b = 7;
        @(posedge clk); #1;
        check("R11 reset", 32'd0, 5'd0, 1'b0, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R11 latency", 32'd12, 5'd3, 1'b1, 1'b0);
    endtask

    task automatic t_add_example;  // R1
        run("R1 add", 32'h0232_4020, 32'd1000, 32'd234);
        check("R1 fixed", 32'd1234, 5'd8, 1'b1, 1'b0);
    endtask

    task automatic t_corners;  // R1 R2 R3 R4
        logic [31:0] cv [5] = '{32'd0, 32'd1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF};
        foreach (cv[i]) foreach (cv[j]) begin
            run("R1 add corner", rtype(4, 5, 6, 0, 32), cv[i], cv[j]);
            run("R2 sub corner", rtype(4, 5, 6, 0, 34), cv[i], cv[j]);
            run("R3 and corner", rtype(4, 5, 6, 0, 36), cv[i], cv[j]);
            run("R3 or corner",  rtype(4, 5, 6, 0, 37), cv[i], cv[j]);
            run("R4 nor corner", rtype(4, 5, 6, 0, 39), cv[i], cv[j]);
        end
        run("R2 wrap", rtype(4, 5, 6, 0, 34), 32'd0, 32'd1);
        check("R2 wrap fixed", 32'hFFFF_FFFF, 5'd6, 1'b1, 1'b0);
    endtask

    task automatic t_not;  // R4
        run("R4 not", rtype(9, 0, 10, 0, 39), 32'h0000_3C00, 32'hDEAD_BEEF);
        check("R4 not fixed", 32'hFFFF_C3FF, 5'd10, 1'b1, 1'b0);
    endtask

    task automatic t_shifts;  // R5 R6
        for (int s = 0; s < 32; s++) begin
            run("R5 sll", rtype(0, 7, 11, s, 0), 32'h0, 32'h8000_0F01);
            run("R5 srl", rtype(0, 7, 11, s, 2), 32'h0, 32'h8000_0F01);
            run("R6 sra", rtype(0, 7, 11, s, 3), 32'h0, 32'h8000_0F01);
            run("R6 sra pos", rtype(0, 7, 11, s, 3), 32'h0, 32'h4000_0F01);
        end
        run("R6 sra 31", rtype(0, 7, 11, 31, 3), 32'h0, 32'h8000_0000);
        check("R6 sra fixed", 32'hFFFF_FFFF, 5'd11, 1'b1, 1'b0);
        run("R5 srl 31", rtype(0, 7, 11, 31, 2), 32'h0, 32'h8000_0000);
        check("R5 srl fixed", 32'h0000_0001, 5'd11, 1'b1, 1'b0);
    endtask

    task automatic t_addi;  // R7
        run("R7 addi neg", itype(8, 3, 12, 16'hFFFE), 32'd10, 32'hAAAA_AAAA);
        check("R7 addi neg fixed", 32'd8, 5'd12, 1'b1, 1'b0);
        run("R7 addi pos", itype(8, 3, 12, 16'h7FFF), 32'd1, 32'h0);
        check("R7 addi pos fixed", 32'h0000_8000, 5'd12, 1'b1, 1'b0);
        run("R7 addi wrap", itype(8, 3, 12, 16'h8000), 32'h8000_0000, 32'h0);
    endtask

    task automatic t_zero_src;  // R8
        run("R8 zero a", rtype(0, 5, 13, 0, 32), 32'h1111_1111, 32'd5);
        check("R8 zero a fixed", 32'd5, 5'd13, 1'b1, 1'b0);
        run("R8 zero b", rtype(5, 0, 13, 0, 37), 32'd6, 32'hFFFF_0000);
        check("R8 zero b fixed", 32'd6, 5'd13, 1'b1, 1'b0);
    endtask

    task automatic t_zero_dst;  // R9
        run("R9 dst0", rtype(1, 2, 0, 0, 32), 32'd3, 32'd4);
        check("R9 dst0 fixed", 32'd7, 5'd0, 1'b0, 1'b0);
        run("R9 addi dst0", itype(8, 1, 0, 16'd1), 32'd3, 32'd4);
    endtask

    task automatic t_illegal;  // R10
        run("R10 bad fn", rtype(1, 2, 3, 0, 33), 32'd3, 32'd4);
        check("R10 bad fn fixed", 32'd0, 5'd3, 1'b0, 1'b1);
        run("R10 bad opc", itype(9, 1, 2, 16'd5), 32'd3, 32'd4);
        run("R10 bad opc lw", itype(35, 1, 2, 16'd5), 32'd3, 32'd4);
        run("R10 bad fn 38", rtype(1, 2, 3, 0, 38), 32'd3, 32'd4);
    endtask

    task automatic t_random;  // R1 R2 R3 R4 R5 R6 R7 R10
        logic [31:0] w, a, b;
        for (int k = 0; k < 400; k++) begin
            lfsr = lfsr * 32'd1664525 + 32'd1013904223; w = lfsr;
            lfsr = lfsr * 32'd1664525 + 32'd1013904223; a = lfsr;
            lfsr = lfsr * 32'd1664525 + 32'd1013904223; b = lfsr;
            if (k % 4 != 3) begin
                if (k % 5 == 0) w[31:26] = 6'd8;
                else begin
                    w[31:26] = 6'd0;
                    case (k % 8)
                        0: w[5:0] = 6'd32; 1: w[5:0] = 6'd34; 2: w[5:0] = 6'd36;
                        3: w[5:0] = 6'd37; 4: w[5:0] = 6'd39; 5: w[5:0] = 6'd0;
                        6: w[5:0] = 6'd2;  default: w[5:0] = 6'd3;
                    endcase
                end
            end
            run("R10 random mix", w, a, b);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_add_example();
        t_corners();
        t_not();
        t_shifts();
        t_addi();
        t_zero_src();
        t_zero_dst();
        t_illegal();
        t_random();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule